// File: doc/BRIEF.md
# Programmable TFT Panel Sync Generator

This block drives the timing controls of a generic active-matrix colour TFT panel from the internal display-interface clock. It divides that clock by two to make a free-running panel clock. It counts pixel slots within a line and lines within a frame, and from these counts it produces a line sync, a frame sync and a data-enable strobe. Pixel words come in on a valid/ready stream and go out on the panel data bus.

Every waveform is placed relative to a local start point, which is slot 0 of each line. The line sync has its own offset, rise and fall counts. The frame sync is placed by line counts plus a slot offset, so its edges always fall on whole lines at one fixed slot. The data window is tied to the local start point and has no offset. This keeps pixel data fixed while the syncs move around it.

Configuration writes go to a pending bank. The pending bank is copied to the live bank at the first slot of each frame, so no frame is ever drawn with mixed settings. Back-pressure rule: the block asks for one word, with `pix_ready` high for one clock, for each data-window slot. A word is taken when `pix_valid` and `pix_ready` are both high. The source cannot stall the raster. If `pix_valid` is low when a word is asked for, that slot sends zero while data-enable stays asserted.

Top module: `tft_sync_gen`

## Requirements
- R1: The slot counter wraps after `line_len` slots and the line counter wraps after `frame_len` lines, so each sync repeats every `line_len` slots and every `line_len*frame_len` slots. Both counters restart at (line 0, slot 0) after reset.
- R2: `panel_clk` toggles on every clock once reset is released. Its first rise comes on the first clock after release. `line_sync`, `frame_sync`, `data_en` and `panel_data` change only on the clock where `panel_clk` rises, so the panel latches on the falling edge.
- R3: Line sync is active in slot h when hs_off+hs_up <= h < hs_off+hs_dn.
- R4: Frame sync is active from slot vs_off of line vs_up up to, but not including, slot vs_off of line vs_dn, measured as (line, slot) pairs. It therefore contains at least one full line-sync pulse whenever that pulse lies inside the lines it covers.
- R5: Data enable is active when de_h0 <= h < de_h1 and de_v0 <= line < de_v1.
- R6: `pix_ready` is high for exactly one clock before each active data slot. `panel_data` carries the word accepted in that handshake for the whole slot. Outside the data window `panel_data` is zero, and with `pix_valid` low inside the window it is also zero.
- R7: Field `pol` (address 12, bits 2:0) inverts, when a bit is 1, bit 0 line sync, bit 1 frame sync and bit 2 data enable, which makes that output active-low.
- R8: A write at address a (0 hs_off, 1 hs_up, 2 hs_dn, 3 vs_off, 4 vs_up, 5 vs_dn, 6 de_h0, 7 de_h1, 8 de_v0, 9 de_v1, 10 line_len, 11 frame_len, 12 pol) has no effect on the outputs until slot 0 of line 0 of the next frame. The live settings never change anywhere else.
- R9: While reset is held, all outputs are at their inactive level for the default polarity: `panel_clk`, syncs, `data_en`, `panel_data` and `pix_ready` are all 0.
- R10: Changing hs_off moves only line sync. The data window and the data sequence do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display-interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration field address (see R8) |
| cfg_wdata | input | CNT_W | Configuration write value |
| pix_valid | input | 1 | Source has a pixel word |
| pix_ready | output | 1 | Block takes a word this clock |
| pix_data | input | DATA_W | Pixel word from source |
| panel_clk | output | 1 | Panel pixel clock, half the input rate |
| line_sync | output | 1 | Line sync to panel |
| frame_sync | output | 1 | Frame sync to panel |
| data_en | output | 1 | Data-valid strobe to panel |
| panel_data | output | DATA_W | Pixel bus to panel |

## Verification
Two events can fall on the same clock: the frame-boundary copy of pending settings, and a configuration write or a pixel handshake. The bench writes new settings in the middle of a frame and checks that every slot up to the end of that frame still matches the old settings. It also checks that from slot 0 of the next frame every slot matches the new ones, including the first data-window handshake after the switch. A slot-accurate model in the bench tracks its own pending and live banks, and every slot of every output is compared against it.

// File: rtl/tft_sync_pkg.sv
package tft_sync_pkg;
  parameter int CNT_W = 12;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [3:0] {
    A_HS_OFF = 4'd0, A_HS_UP = 4'd1, A_HS_DN = 4'd2,
    A_VS_OFF = 4'd3, A_VS_UP = 4'd4, A_VS_DN = 4'd5,
    A_DE_H0  = 4'd6, A_DE_H1 = 4'd7, A_DE_V0 = 4'd8, A_DE_V1 = 4'd9,
    A_LINE   = 4'd10, A_FRAME = 4'd11, A_POL = 4'd12
  } cfg_addr_e;

  // waveform placement, all relative to the local start point
  typedef struct packed {
    cnt_t hs_off, hs_up, hs_dn;
    cnt_t vs_off, vs_up, vs_dn;
    cnt_t de_h0, de_h1, de_v0, de_v1;
    logic [2:0] pol;
  } place_cfg_t;

  typedef struct packed {
    cnt_t       line_len;
    cnt_t       frame_len;
    place_cfg_t place;
  } timing_cfg_t;
endpackage

// File: rtl/tft_cfg_bank.sv
module tft_cfg_bank
  import tft_sync_pkg::*;
#(
  parameter timing_cfg_t RST_CFG = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  cnt_t        wr_data,
  input  logic        swap,
  output timing_cfg_t cur_cfg,
  output place_cfg_t  nxt_place
);
  timing_cfg_t pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= RST_CFG;
      cur_cfg <= RST_CFG;
    end else begin
      if (swap) cur_cfg <= pend;
      if (wr_en) begin
        unique case (cfg_addr_e'(wr_addr))
          A_HS_OFF: pend.place.hs_off <= wr_data;
          A_HS_UP:  pend.place.hs_up  <= wr_data;
          A_HS_DN:  pend.place.hs_dn  <= wr_data;
          A_VS_OFF: pend.place.vs_off <= wr_data;
          A_VS_UP:  pend.place.vs_up  <= wr_data;
          A_VS_DN:  pend.place.vs_dn  <= wr_data;
          A_DE_H0:  pend.place.de_h0  <= wr_data;
          A_DE_H1:  pend.place.de_h1  <= wr_data;
          A_DE_V0:  pend.place.de_v0  <= wr_data;
          A_DE_V1:  pend.place.de_v1  <= wr_data;
          A_LINE:   pend.line_len     <= wr_data;
          A_FRAME:  pend.frame_len    <= wr_data;
          A_POL:    pend.place.pol    <= wr_data[2:0];
          default:  ;
        endcase
      end
    end
  end

  // the first slot of a new frame is computed with the settings it will run under
  assign nxt_place = swap ? pend.place : cur_cfg.place;
endmodule

// File: rtl/tft_raster_cnt.sv
module tft_raster_cnt
  import tft_sync_pkg::*;
#(
  parameter cnt_t RST_H = '0,
  parameter cnt_t RST_V = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  cnt_t line_len,
  input  cnt_t frame_len,
  output logic ph,
  output logic tick,
  output logic frame_wrap,
  output cnt_t h,
  output cnt_t h_nxt,
  output cnt_t v_nxt
);
  cnt_t v;
  logic h_wrap, v_wrap;

  always_comb begin
    h_wrap     = (h >= line_len - cnt_t'(1));
    v_wrap     = (v >= frame_len - cnt_t'(1));
    tick       = ~ph;
    h_nxt      = h_wrap ? '0 : h + cnt_t'(1);
    v_nxt      = h_wrap ? (v_wrap ? '0 : v + cnt_t'(1)) : v;
    frame_wrap = tick & h_wrap & v_wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= 1'b0;
      h  <= RST_H;
      v  <= RST_V;
    end else begin
      ph <= ~ph;
      if (tick) begin
        h <= h_nxt;
        v <= v_nxt;
      end
    end
  end
endmodule

// File: rtl/tft_wave_gen.sv
module tft_wave_gen
  import tft_sync_pkg::*;
#(
  parameter int         DATA_W  = 24,
  parameter logic [2:0] RST_POL = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  place_cfg_t        pc,
  input  cnt_t              h,
  input  cnt_t              v,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              line_sync,
  output logic              frame_sync,
  output logic              data_en,
  output logic [DATA_W-1:0] panel_data
);
  localparam int SUM_W = CNT_W + 1;
  localparam int POS_W = 2 * CNT_W;

  logic [SUM_W-1:0] hs_rise, hs_fall, h_ext;
  logic [POS_W-1:0] pos, vs_lo, vs_hi;
  logic hs_on, vs_on, de_on;

  always_comb begin
    h_ext   = {1'b0, h};
    hs_rise = {1'b0, pc.hs_off} + {1'b0, pc.hs_up};
    hs_fall = {1'b0, pc.hs_off} + {1'b0, pc.hs_dn};
    hs_on   = (h_ext >= hs_rise) && (h_ext < hs_fall);
    pos     = {v, h};
    vs_lo   = {pc.vs_up, pc.vs_off};
    vs_hi   = {pc.vs_dn, pc.vs_off};
    vs_on   = (pos >= vs_lo) && (pos < vs_hi);
    de_on   = (h >= pc.de_h0) && (h < pc.de_h1) &&
              (v >= pc.de_v0) && (v < pc.de_v1);
    pix_ready = tick & de_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_sync  <= RST_POL[0];
      frame_sync <= RST_POL[1];
      data_en    <= RST_POL[2];
      panel_data <= '0;
    end else if (tick) begin
      line_sync  <= hs_on ^ pc.pol[0];
      frame_sync <= vs_on ^ pc.pol[1];
      data_en    <= de_on ^ pc.pol[2];
      panel_data <= (de_on && pix_valid) ? pix_data : '0;
    end
  end
endmodule

// File: rtl/tft_sync_gen.sv
module tft_sync_gen
  import tft_sync_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int DEF_LINE   = 16,
  parameter int DEF_FRAME  = 8,
  parameter int DEF_HS_OFF = 0,
  parameter int DEF_HS_UP  = 1,
  parameter int DEF_HS_DN  = 3,
  parameter int DEF_VS_OFF = 0,
  parameter int DEF_VS_UP  = 1,
  parameter int DEF_VS_DN  = 2,
  parameter int DEF_DE_H0  = 4,
  parameter int DEF_DE_H1  = 14,
  parameter int DEF_DE_V0  = 3,
  parameter int DEF_DE_V1  = 7,
  parameter int DEF_POL    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [DATA_W-1:0] pix_data,
  output logic              panel_clk,
  output logic              line_sync,
  output logic              frame_sync,
  output logic              data_en,
  output logic [DATA_W-1:0] panel_data
);
  localparam place_cfg_t RST_PLACE = '{
    hs_off: cnt_t'(DEF_HS_OFF), hs_up: cnt_t'(DEF_HS_UP), hs_dn: cnt_t'(DEF_HS_DN),
    vs_off: cnt_t'(DEF_VS_OFF), vs_up: cnt_t'(DEF_VS_UP), vs_dn: cnt_t'(DEF_VS_DN),
    de_h0: cnt_t'(DEF_DE_H0), de_h1: cnt_t'(DEF_DE_H1),
    de_v0: cnt_t'(DEF_DE_V0), de_v1: cnt_t'(DEF_DE_V1),
    pol: 3'(DEF_POL)};
  localparam timing_cfg_t RST_CFG = '{
    line_len: cnt_t'(DEF_LINE), frame_len: cnt_t'(DEF_FRAME), place: RST_PLACE};

  timing_cfg_t cur_cfg;
  place_cfg_t  nxt_place;
  logic        ph, tick, frame_wrap;
  cnt_t        h_now, h_nxt, v_nxt;

  tft_cfg_bank #(.RST_CFG(RST_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .swap(frame_wrap),
    .cur_cfg(cur_cfg), .nxt_place(nxt_place));

  // counters start on the last slot so the first tick lands on (0,0)
  tft_raster_cnt #(
    .RST_H(cnt_t'(DEF_LINE - 1)), .RST_V(cnt_t'(DEF_FRAME - 1))
  ) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .line_len(cur_cfg.line_len), .frame_len(cur_cfg.frame_len),
    .ph(ph), .tick(tick), .frame_wrap(frame_wrap),
    .h(h_now), .h_nxt(h_nxt), .v_nxt(v_nxt));

  tft_wave_gen #(.DATA_W(DATA_W), .RST_POL(3'(DEF_POL))) u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pc(nxt_place),
    .h(h_nxt), .v(v_nxt), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .line_sync(line_sync), .frame_sync(frame_sync),
    .data_en(data_en), .panel_data(panel_data));

  assign panel_clk = ph;
endmodule

// File: rtl/tft_sync_gen_chk.sv
module tft_sync_gen_chk
  import tft_sync_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              panel_clk,
  input logic              line_sync,
  input logic              frame_sync,
  input logic              data_en,
  input logic [DATA_W-1:0] panel_data,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              frame_wrap,
  input timing_cfg_t       cur_cfg,
  input cnt_t              h_now
);
  // R1
  slot_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_now < cur_cfg.line_len);

  // R2
  clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (panel_clk != $past(panel_clk)));

  // R2
  outputs_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$rose(panel_clk)) |->
      ($stable(line_sync) && $stable(frame_sync) && $stable(data_en) && $stable(panel_data)));

  // R6
  ready_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |=> $rose(panel_clk));

  // R6
  data_from_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_data != '0) |-> ($past(pix_valid && pix_ready) || $past(pix_valid && pix_ready, 2)));

  // R8
  cfg_only_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(frame_wrap)) |-> $stable(cur_cfg));
endmodule

bind tft_sync_gen tft_sync_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .panel_clk(panel_clk), .line_sync(line_sync),
  .frame_sync(frame_sync), .data_en(data_en), .panel_data(panel_data),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .frame_wrap(frame_wrap),
  .cur_cfg(cur_cfg), .h_now(h_now));

// File: tb/sim_tft_sync_gen.sv
`timescale 1ns/1ps
module sim_tft_sync_gen;
  localparam int DW = 24;
  localparam int HI = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic pix_valid = 1'b1, pix_ready;
  logic [DW-1:0] pix_data = 1;
  logic panel_clk, line_sync, frame_sync, data_en;
  logic [DW-1:0] panel_data;

  int checks = 0, fails = 0;
  int bp[13], mc[13];
  int mh, mv, mf, kcnt, exp_seq;
  bit mon_on = 0;
  int e_hs, e_vs, e_de, e_dat, e_clk, e_rdy, e_f0, e_span;
  bit prev_vs, prev_hs, hs_in_vs;

  always #2.5 clk = ~clk;

  tft_sync_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .panel_clk(panel_clk), .line_sync(line_sync),
    .frame_sync(frame_sync), .data_en(data_en), .panel_data(panel_data));

  // source: next word after each accepted handshake
  always @(posedge clk) if (pix_valid && pix_ready) pix_data <= pix_data + 1;

  function automatic bit m_hs(int h);
    return (h >= mc[0] + mc[1]) && (h < mc[0] + mc[2]);
  endfunction
  function automatic bit m_vs(int h, int v);
    int p = v * HI + h;
    return (p >= mc[4] * HI + mc[3]) && (p < mc[5] * HI + mc[3]);
  endfunction
  function automatic bit m_de(int h, int v);
    return (h >= mc[6]) && (h < mc[7]) && (v >= mc[8]) && (v < mc[9]);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // slot-accurate reference, sampled on falling clock edges
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      kcnt++;
      if (kcnt % 2 == 1) begin
        bit ehs, evs, ede, ahs, avs;
        int edat;
        ehs = m_hs(mh) ^ mc[12][0];
        evs = m_vs(mh, mv) ^ mc[12][1];
        ede = m_de(mh, mv) ^ mc[12][2];
        edat = 0;
        if (m_de(mh, mv) && pix_valid) begin edat = exp_seq; exp_seq++; end
        if (panel_clk !== 1'b1) e_clk++;
        if (line_sync !== ehs) e_hs++;
        if (frame_sync !== evs) e_vs++;
        if (data_en !== ede) e_de++;
        if (panel_data !== DW'(edat)) e_dat++;
        if (mf == 0 && (line_sync !== ehs || frame_sync !== evs || data_en !== ede)) e_f0++;
        ahs = line_sync ^ mc[12][0];
        avs = frame_sync ^ mc[12][1];
        if (avs && ahs && !prev_hs) hs_in_vs = 1;
        if (!avs && prev_vs) begin
          if (!hs_in_vs) e_span++;
          hs_in_vs = 0;
        end
        prev_vs = avs; prev_hs = ahs;
      end else begin
        if (panel_clk !== 1'b0) e_clk++;
        mh++;
        if (mh >= mc[10]) begin
          mh = 0; mv++;
          if (mv >= mc[11]) begin mv = 0; mf++; mc = bp; end
        end
        if (pix_ready !== m_de(mh, mv)) e_rdy++;
      end
    end
  end

  task automatic do_reset(bit valid);
    @(negedge clk);
    rst_n = 0; mon_on = 0; pix_valid = valid;
    bp = '{0, 1, 3, 0, 1, 2, 4, 14, 3, 7, 16, 8, 0};
    repeat (3) @(negedge clk);
    pix_data = 1;
    #1;
    mc = bp; mh = 0; mv = 0; mf = 0; kcnt = 0; exp_seq = 1;
    e_hs = 0; e_vs = 0; e_de = 0; e_dat = 0; e_clk = 0; e_rdy = 0; e_f0 = 0; e_span = 0;
    prev_vs = 0; prev_hs = 0; hs_in_vs = 0;
    rst_n = 1; mon_on = 1;
  endtask

  task automatic wr(int a, int val);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 12'(val);
    @(posedge clk); #1;
    bp[a] = (a == 12) ? (val & 7) : val;
    cfg_we = 0;
  endtask

  task automatic prog(int hs_off, int pol, int line_len);
    wr(0, hs_off); wr(1, 1); wr(2, 4); wr(3, 5); wr(4, 1); wr(5, 3);
    wr(6, 6); wr(7, 18); wr(8, 2); wr(9, 5); wr(10, line_len); wr(11, 6); wr(12, pol);
  endtask

  task automatic run_slots(int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0; mon_on = 0;
    repeat (3) @(negedge clk);
    chk({panel_clk, line_sync, frame_sync, data_en, pix_ready} == 5'b0, "R9 reset levels",
        {panel_clk, line_sync, frame_sync, data_en, pix_ready}, 0);
    chk(panel_data == '0, "R9 reset data", int'(panel_data), 0);
  endtask

  task automatic t_basic();
    do_reset(1);
    prog(2, 0, 20);
    run_slots(128 + 240 + 20);
    chk(e_f0 == 0, "R8 old settings hold to frame end", e_f0, 0);
    chk(e_hs == 0, "R1 R3 line sync placement", e_hs, 0);
    chk(e_vs == 0, "R4 frame sync placement", e_vs, 0);
    chk(e_span == 0, "R4 frame sync spans a line sync", e_span, 0);
    chk(e_de == 0, "R5 data window", e_de, 0);
    chk(e_dat == 0, "R6 data sequence", e_dat, 0);
    chk(e_rdy == 0, "R6 ready strobe", e_rdy, 0);
    chk(e_clk == 0, "R2 panel clock", e_clk, 0);
    chk(mf >= 2, "R1 frames completed", mf, 2);
  endtask

  task automatic t_polarity();
    do_reset(1);
    prog(9, 7, 20);
    run_slots(128 + 240 + 20);
    chk(e_hs == 0 && e_vs == 0, "R7 inverted syncs", e_hs + e_vs, 0);
    chk(e_de == 0, "R7 inverted data enable", e_de, 0);
    chk(e_dat == 0 && e_rdy == 0, "R10 data fixed when line sync shifts", e_dat + e_rdy, 0);
  endtask

  task automatic t_underrun();
    do_reset(0);
    prog(2, 0, 20);
    run_slots(128 + 130);
    chk(e_dat == 0, "R6 zero data without valid", e_dat, 0);
    chk(e_de == 0, "R6 data enable kept without valid", e_de, 0);
  endtask

  task automatic t_midframe();
    do_reset(1);
    prog(2, 0, 20);
    run_slots(128 + 30);
    wr(0, 7); wr(10, 24); wr(12, 1);
    run_slots(300 + 2 * 144);
    chk(mf >= 3, "R8 frames completed", mf, 3);
    chk(e_hs == 0 && e_vs == 0 && e_de == 0, "R8 mid-frame write deferred",
        e_hs + e_vs + e_de, 0);
    chk(e_dat == 0 && e_rdy == 0, "R6 handshake across switch", e_dat + e_rdy, 0);
    chk(e_clk == 0, "R2 clock continuous across switch", e_clk, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_polarity();
    t_underrun();
    t_midframe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule